// File: doc/BRIEF.md
# Dual-Width Local Register Port

This block is the slave side of a local processor bus that reaches a small bank of 32-bit operation registers, an interrupt enable register and a latched interrupt status register. The processor presents a word address, active-low byte enables, a chip select and separate active-low read and write strobes. The processor may run from a clock that is unrelated to the block clock. A static width pin turns the 32-bit port into a 16-bit port. In that mode the byte-enable pin of the top byte serves as the half-word address bit, so two 16-bit cycles reach each 32-bit register.

Writes are asynchronous. Chip select and the write strobe pass through a two-stage synchroniser, and the write takes effect once, after the strobe is released. Reads work like an asynchronous memory. The data bus is split into an input, an output and two half-word output enables, so the pad ring can build the bidirectional pins. Interrupt sources come in as one-cycle or level events. They latch into the status register and pull the active-low interrupt pin while any latched bit is also enabled.

Top module: `regport_bus`

## Requirements
- R1: After reset every register reads zero, `irq_n` is high and `dq_oe` is 2'b00.
- R2: `dq_oe[0]` is high only while `cs_n` and `rd_n` are both low. `dq_oe[1]` follows it in 32-bit mode and stays low in 16-bit mode (`mode16`=1).
- R3: In 32-bit mode a write updates byte lane i (bits 8i+7:8i) only when `be_n[i]` is 0. The other bytes keep their value.
- R4: A write needs `cs_n` and `wr_n` low together. It commits exactly once, at the third rising clock edge after the strobe is released, and not earlier. A write strobe with `cs_n` high changes nothing.
- R5: In 16-bit mode a read returns bits 15:0 of the register on `dq_o[15:0]` when `be_n[3]`=0, and bits 31:16 when `be_n[3]`=1.
- R6: In 16-bit mode `be_n[1:0]` enable the two bytes of `dq_i[15:0]`. These bytes are written to register bits 15:0 when `be_n[3]`=0 and to bits 31:16 when `be_n[3]`=1. `be_n[2]` and `dq_i[31:16]` are ignored.
- R7: Word addresses 0 to REG_COUNT-1 (default 4) are read/write registers. Address 30 is interrupt status and address 31 is interrupt enable. Other addresses read zero and ignore writes.
- R8: A high `irq_event[i]` at a clock edge sets status bit i. `irq_n` is low exactly while some status bit is set whose enable bit is also 1.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: If an event for a status bit arrives at the same edge as a clearing write to that bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode16 | input | 1 | Static width select: 0 = 32-bit, 1 = 16-bit |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| be_n | input | 4 | Active-low byte enables; in 16-bit mode bit 3 is the half-word address bit |
| addr | input | 5 | Word address (byte address bits 6:2) |
| dq_i | input | 32 | Data from the bus pins |
| dq_o | output | 32 | Data toward the bus pins |
| dq_oe | output | 2 | Output enable per half-word (bit 0 for lines 15:0, bit 1 for lines 31:16) |
| irq_event | input | IRQ_W | Interrupt source events, active high |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A write is due at the third rising edge after its strobe is released. The bench checks the old value with a read that is sampled one edge after the release, and it reads the new value only after that third edge. Read data and output enables are combinational from the pins. The scoreboard therefore samples them just after the first rising edge following the negative edge at which the read was driven. A status bit is set at the edge that samples its event, and `irq_n` is checked at the following negative edge. The same-edge event case places the event on the commit edge itself.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LANES = DW / 8;
  localparam int unsigned AW    = 5;

  // Byte-lane merge for both widths; merging into zero yields the written-ones mask.
  function automatic logic [DW-1:0] lane_merge(
    input logic [DW-1:0]    old_v,
    input logic [DW-1:0]    wd,
    input logic [LANES-1:0] be_n,
    input logic             m16
  );
    logic [LANES-1:0] en;
    logic [DW-1:0]    src;
    logic [DW-1:0]    res;
    if (m16) begin
      en  = be_n[3] ? {~be_n[1], ~be_n[0], 2'b00} : {2'b00, ~be_n[1], ~be_n[0]};
      src = {wd[15:0], wd[15:0]};
    end else begin
      en  = ~be_n;
      src = wd;
    end
    for (int i = 0; i < LANES; i++)
      res[8*i +: 8] = en[i] ? src[8*i +: 8] : old_v[8*i +: 8];
    return res;
  endfunction

  // Read lane steering: 16-bit mode returns the selected half on the low lines.
  function automatic logic [DW-1:0] read_lanes(
    input logic [DW-1:0] v,
    input logic          m16,
    input logic          a1
  );
    logic [15:0] hi;
    logic [15:0] lo;
    hi = m16 ? 16'h0000 : v[31:16];
    lo = (m16 && a1) ? v[31:16] : v[15:0];
    return {hi, lo};
  endfunction
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/regport_wstrobe.sv
module regport_wstrobe
  import regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_i,
  input  logic [LANES-1:0] be_n,
  output logic             commit,
  output logic [AW-1:0]    w_addr,
  output logic [DW-1:0]    w_data,
  output logic [LANES-1:0] w_be_n
);
  logic [1:0] strb_s;
  logic       act;
  logic       act_q;

  regport_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, wr_n}),
    .q     (strb_s)
  );

  assign act    = ~strb_s[1] & ~strb_s[0];
  assign commit = act_q & ~act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      w_addr <= '0;
      w_data <= '0;
      w_be_n <= '1;
    end else begin
      act_q <= act;
      if (act) begin
        w_addr <= addr;
        w_data <= dq_i;
        w_be_n <= be_n;
      end
    end
  end
endmodule

// File: rtl/regport_irq.sv
module regport_irq #(
  parameter int unsigned IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] evt,
  input  logic [IRQ_W-1:0] clr,
  input  logic [IRQ_W-1:0] ien,
  output logic [IRQ_W-1:0] isr,
  output logic             irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~clr) | evt;
  end

  assign irq_n = ~|(isr & ien);
endmodule

// File: rtl/regport_bus.sv
module regport_bus
  import regport_pkg::*;
#(
  parameter int unsigned REG_COUNT = 4,
  parameter int unsigned IRQ_W     = 8,
  parameter int unsigned ISR_ADDR  = 30,
  parameter int unsigned IEN_ADDR  = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode16,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [3:0]       be_n,
  input  logic [4:0]       addr,
  input  logic [31:0]      dq_i,
  output logic [31:0]      dq_o,
  output logic [1:0]       dq_oe,
  input  logic [IRQ_W-1:0] irq_event,
  output logic             irq_n
);
  localparam logic [AW-1:0] ISR_A = AW'(ISR_ADDR);
  localparam logic [AW-1:0] IEN_A = AW'(IEN_ADDR);

  logic             wr_commit;
  logic [AW-1:0]    w_addr;
  logic [DW-1:0]    w_data;
  logic [LANES-1:0] w_be_n;
  logic [DW-1:0]    w_ones;
  logic [IRQ_W-1:0] isr_q;
  logic [IRQ_W-1:0] ien_q;
  logic [IRQ_W-1:0] isr_clr;
  logic [DW-1:0]    bank_q [REG_COUNT];
  logic [DW-1:0]    rd_word;
  logic             rd_en;

  regport_wstrobe u_wstrobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .dq_i   (dq_i),
    .be_n   (be_n),
    .commit (wr_commit),
    .w_addr (w_addr),
    .w_data (w_data),
    .w_be_n (w_be_n)
  );

  // Bits the processor wrote as one in enabled lanes.
  assign w_ones  = lane_merge('0, w_data, w_be_n, mode16);
  assign isr_clr = (wr_commit && w_addr == ISR_A) ? w_ones[IRQ_W-1:0] : '0;

  genvar g;
  generate
    for (g = 0; g < REG_COUNT; g++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank_q[g] <= '0;
        else if (wr_commit && w_addr == AW'(g))
          bank_q[g] <= lane_merge(bank_q[g], w_data, w_be_n, mode16);
      end
    end
  endgenerate

  logic [DW-1:0] ien_wide;
  assign ien_wide = DW'(ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ien_q <= '0;
    else if (wr_commit && w_addr == IEN_A)
      ien_q <= lane_merge(ien_wide, w_data, w_be_n, mode16)[IRQ_W-1:0];
  end

  regport_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (irq_event),
    .clr   (isr_clr),
    .ien   (ien_q),
    .isr   (isr_q),
    .irq_n (irq_n)
  );

  always_comb begin
    rd_word = '0;
    if (addr == ISR_A)
      rd_word = DW'(isr_q);
    else if (addr == IEN_A)
      rd_word = ien_wide;
    else
      for (int i = 0; i < REG_COUNT; i++)
        if (addr == AW'(i)) rd_word = bank_q[i];
  end

  assign rd_en = ~cs_n & ~rd_n;
  assign dq_o  = read_lanes(rd_word, mode16, be_n[3]);
  assign dq_oe = {rd_en & ~mode16, rd_en};
endmodule

// File: rtl/regport_bus_chk.sv
module regport_bus_chk #(
  parameter int unsigned IRQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             wr_n,
  input logic             irq_n,
  input logic             commit,
  input logic [IRQ_W-1:0] irq_event,
  input logic [IRQ_W-1:0] isr,
  input logic [IRQ_W-1:0] ien,
  input logic [IRQ_W-1:0] isr_clr
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (isr == '0 && irq_n));

  // R4: one commit per strobe, only after the pins were released
  a_r4_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  a_r4_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(wr_n, 2) || $past(cs_n, 2)));

  // R8
  a_r8_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(irq_event & ien)) && !commit) |=> !irq_n);

  // R9
  a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr_clr & ~irq_event)) |=> ((isr & $past(isr_clr & ~irq_event)) == '0));

  // R10
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_event) |=> ((isr & $past(irq_event)) == $past(irq_event)));
endmodule

bind regport_bus regport_bus_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .wr_n      (wr_n),
  .irq_n     (irq_n),
  .commit    (wr_commit),
  .irq_event (irq_event),
  .isr       (isr_q),
  .ien       (ien_q),
  .isr_clr   (isr_clr)
);

// File: tb/regport_bus_bench.sv
`timescale 1ns/1ps
module regport_bus_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode16 = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [3:0]  be_n = 4'hF;
  logic [4:0]  addr = '0;
  logic [31:0] dq_i = '0;
  logic [31:0] dq_o;
  logic [1:0]  dq_oe;
  logic [7:0]  irq_event = '0;
  logic        irq_n;

  int n_chk = 0;
  int n_fail = 0;
  logic rd_sample = 1'b0;
  bit   done = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic [1:0]  oe;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #2.5 clk = ~clk;

  regport_bus u_regport_bus (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .be_n(be_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .irq_event(irq_event), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_read(input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.data = exp;
    it.oe   = mode16 ? 2'b01 : 2'b11;
    it.tag  = tag;
    sb_q.push_back(it);
    rd_sample = 1'b1;
  endtask

  // Monitor: pops an expected item for each read and compares bus and enables.
  always @(posedge clk) begin
    #1;
    if (rd_sample && sb_q.size() > 0) begin
      rd_item_t it;
      logic [31:0] got;
      it  = sb_q.pop_front();
      got = {dq_oe[1] ? dq_o[31:16] : 16'h0, dq_oe[0] ? dq_o[15:0] : 16'h0};
      check(got == it.data, it.tag, got, it.data);
      check(dq_oe == it.oe, {it.tag, " R2 oe"}, 32'(dq_oe), 32'(it.oe));
    end
  end

  task automatic rd_check(input logic [4:0] a, input logic a1,
                          input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; be_n = {a1, 3'b000}; cs_n = 1'b0; rd_n = 1'b0;
    push_read(exp, tag);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; rd_sample = 1'b0;
  endtask

  // Commit is due at the third rising edge after release (N3 below).
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d,
                           input logic [3:0] be, input bit peek,
                           input logic [31:0] peek_exp, input logic [7:0] ev);
    @(negedge clk);
    addr = a; dq_i = d; be_n = be; cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    if (peek) begin
      cs_n = 1'b0; rd_n = 1'b0;
      push_read(peek_exp, "R4 value unchanged before commit edge");
    end
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; rd_sample = 1'b0; irq_event = ev;
    @(negedge clk);
    irq_event = '0;
  endtask

  task automatic pulse_event(input logic [7:0] v);
    @(negedge clk);
    irq_event = v;
    @(negedge clk);
    irq_event = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(irq_n == 1'b1, "R1 irq_n idle after reset", 32'(irq_n), 32'd1);
    check(dq_oe == 2'b00, "R1 no drive in reset", 32'(dq_oe), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dq_oe == 2'b00, "R2 idle bus not driven", 32'(dq_oe), 32'd0);
    rd_check(5'd0, 1'b0, 32'h0, "R1 reg0 zero");
    rd_check(5'd30, 1'b0, 32'h0, "R1 status zero");

    // 32-bit mode
    bus_write(5'd0, 32'h11223344, 4'b0000, 1'b1, 32'h0, 8'h00);
    rd_check(5'd0, 1'b0, 32'h11223344, "R3 full word write");
    bus_write(5'd0, 32'hAABBCCDD, 4'b1010, 1'b1, 32'h11223344, 8'h00);
    rd_check(5'd0, 1'b0, 32'h11BB33DD, "R3 lanes 0 and 2 only");

    // Write strobe without chip select
    @(negedge clk);
    addr = 5'd1; dq_i = 32'hFFFFFFFF; be_n = 4'h0; wr_n = 1'b0;
    repeat (6) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_check(5'd1, 1'b0, 32'h0, "R4 no write without chip select");

    // Decode
    bus_write(5'd4, 32'hDEADBEEF, 4'b0000, 1'b0, 32'h0, 8'h00);
    rd_check(5'd4, 1'b0, 32'h0, "R7 unmapped address reads zero");
    rd_check(5'd0, 1'b0, 32'h11BB33DD, "R7 unmapped write touched no register");
    bus_write(5'd3, 32'h0BADF00D, 4'b0000, 1'b0, 32'h0, 8'h00);
    rd_check(5'd3, 1'b0, 32'h0BADF00D, "R7 last bank register");

    // 16-bit mode
    @(negedge clk);
    mode16 = 1'b1;
    rd_check(5'd0, 1'b0, 32'h000033DD, "R5 low half");
    rd_check(5'd0, 1'b1, 32'h000011BB, "R5 high half");
    bus_write(5'd0, 32'hFFFF5566, 4'b1000, 1'b1, 32'h000011BB, 8'h00);
    rd_check(5'd0, 1'b1, 32'h00005566, "R6 upper half, be_n[2] low ignored");
    bus_write(5'd0, 32'h000099AA, 4'b1101, 1'b0, 32'h0, 8'h00);
    rd_check(5'd0, 1'b1, 32'h00009966, "R6 single byte into bits 31:24");
    bus_write(5'd0, 32'h00007788, 4'b0001, 1'b0, 32'h0, 8'h00);
    rd_check(5'd0, 1'b0, 32'h000077DD, "R6 single byte into bits 15:8");
    @(negedge clk);
    mode16 = 1'b0;
    rd_check(5'd0, 1'b0, 32'h996677DD, "R6 R3 whole word after half writes");

    // Interrupts
    bus_write(5'd31, 32'h000000FF, 4'b0000, 1'b0, 32'h0, 8'h00);
    pulse_event(8'h04);
    check(irq_n == 1'b0, "R8 enabled source asserts irq_n", 32'(irq_n), 32'd0);
    rd_check(5'd30, 1'b0, 32'h04, "R8 status latched");
    bus_write(5'd30, 32'h0, 4'b0000, 1'b0, 32'h0, 8'h00);
    rd_check(5'd30, 1'b0, 32'h04, "R9 writing zero keeps bit");
    bus_write(5'd30, 32'h04, 4'b0000, 1'b0, 32'h0, 8'h00);
    rd_check(5'd30, 1'b0, 32'h00, "R9 writing one clears bit");
    check(irq_n == 1'b1, "R9 irq_n released after clear", 32'(irq_n), 32'd1);
    bus_write(5'd31, 32'h01, 4'b0000, 1'b0, 32'h0, 8'h00);
    pulse_event(8'h08);
    check(irq_n == 1'b1, "R8 masked source leaves irq_n high", 32'(irq_n), 32'd1);
    rd_check(5'd30, 1'b0, 32'h08, "R8 masked source still latched");
    bus_write(5'd30, 32'h08, 4'b0000, 1'b0, 32'h0, 8'h08);
    rd_check(5'd30, 1'b0, 32'h08, "R10 event beats same-edge clear");
    bus_write(5'd30, 32'h08, 4'b0000, 1'b0, 32'h0, 8'h00);
    rd_check(5'd30, 1'b0, 32'h00, "R9 later clear succeeds");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule